// File: doc/BRIEF.md
# Backplane Interrupt Line Router

This block collects interrupt requests from up to 32 backplane sources and places them on five processor interrupt lines. Each source is known by a 6-bit flag number, which here is the index of its request bit. Four dedicated lines, numbered 1 to 4, each follow exactly one source. The source for a line is chosen by a flag field stored in a selection register. Line 0 is shared: it carries the OR of every source whose bit is set in an enable vector register.

Software programs both registers through a single-cycle read/write port. A combinational query port takes a flag number and reports where that source is routed. It returns the lowest matching dedicated line, the shared line, a disabled code, or a no-capability code. It also returns the matching processor interrupt number.

Top module: `irq_router`

## Requirements
- R1: After reset every line field holds 0x3F, the vector register holds zero, all five irqLine outputs are low, the selection register reads 0x3F3F3F3F and the vector register reads 0.
- R2: The selection register sits at address 0. Its four 6-bit fields are at bits [5:0] (line 1), [13:8] (line 2), [21:16] (line 3) and [29:24] (line 4). The bits outside these fields are discarded on write and read as zero.
- R3: Dedicated line k (irqLine[k]) goes high one clock after srcReq[f] goes high, where f is the value in line k's field. A field value of 32 or more, including the released value 0x3F, keeps the line low.
- R4: The vector register sits at address 1. One clock after the inputs change, irqLine[0] equals the OR over all n of srcReq[n] AND vector bit n.
- R5: qryLine returns 6 when qryFlag is 0x3F. Otherwise it returns the lowest line k (1 to 4) whose field equals qryFlag. If no field matches, it returns 0 when qryFlag is below 32 and its vector bit is set, and 5 in all other cases.
- R6: qryIrq equals qryLine + 2 when qryLine is 0 to 4, and 0 when qryLine is 5 or 6.
- R7: Writing zero to the vector register removes every shared-line assignment at once. From the next cycle, no query returns 0, and one cycle after that irqLine[0] is low.
- R8: A write takes effect at the clock edge where wrEn is high. rdData shows the register selected by regAddr in the same cycle, with the value it held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | 0 = selection register, 1 = vector register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for regAddr |
| srcReq | input | 32 | Request level of the source with flag n on bit n |
| irqLine | output | 5 | Registered line levels; bit 0 is the shared line |
| qryFlag | input | 6 | Flag number to look up |
| qryLine | output | 3 | Routing code 0..6 |
| qryIrq | output | 4 | Processor interrupt number, or 0 when unrouted |

## Verification
The bench sets the same flag in several fields and checks that the query reports the lowest line. A wrong priority order would report line 4 instead of line 1. It places an out-of-range flag (32) in a field, which a design that truncated the index would wrongly route to source 0. It writes ones into the gap bits of the selection register, where a bad mask would show up in readback. It clears the vector register while line 0 is active, which a design with a stale enable would leave asserted. It looks up flag 0x3F while every vector bit is set and the fields are released, which must give code 6 rather than a match.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int FLAG_W = 6;
  localparam int CODE_W = 3;
  localparam logic [CODE_W-1:0] CODE_SHARED = 3'd0;
  localparam logic [CODE_W-1:0] CODE_OFF    = 3'd5;
  localparam logic [CODE_W-1:0] CODE_NOCAP  = 3'd6;
  localparam logic [FLAG_W-1:0] FLAG_NONE   = 6'h3F;

  typedef struct packed {
    logic selWr;
    logic vecWr;
    logic rdVec;
  } regStrobe_t;
endpackage

// File: rtl/irq_router_ctrl.sv
module irq_router_ctrl
  import irq_router_pkg::*;
(
  input  logic       wrEn,
  input  logic       regAddr,
  output regStrobe_t strb
);
  always_comb begin
    strb.selWr = wrEn && !regAddr;
    strb.vecWr = wrEn && regAddr;
    strb.rdVec = regAddr;
  end
endmodule

// File: rtl/irq_router_dp.sv
module irq_router_dp
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int NUM_DED = 4,
  parameter int DATA_W  = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  regStrobe_t          strb,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdData,
  input  logic [NUM_SRC-1:0]  srcReq,
  output logic [NUM_DED:0]    irqLine,
  input  logic [FLAG_W-1:0]   qryFlag,
  output logic [CODE_W-1:0]   qryLine,
  output logic [3:0]          qryIrq
);
  localparam int IDX_W  = $clog2(NUM_SRC);
  localparam int STRIDE = 8;
  localparam logic [FLAG_W-1:0] SRC_LIMIT = FLAG_W'(NUM_SRC);

  logic [FLAG_W-1:0]  field [NUM_DED];
  logic [NUM_SRC-1:0] vecReg;
  logic [NUM_DED:0]   lineNext;
  logic [DATA_W-1:0]  selRead;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) vecReg <= '0;
    else if (strb.vecWr) vecReg <= wrData[NUM_SRC-1:0];
  end

  assign lineNext[0] = |(srcReq & vecReg);

  for (genvar k = 0; k < NUM_DED; k++) begin : gLine
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) field[k] <= FLAG_NONE;
      else if (strb.selWr) field[k] <= wrData[k*STRIDE +: FLAG_W];
    end
    assign lineNext[k+1] = (field[k] < SRC_LIMIT) && srcReq[field[k][IDX_W-1:0]];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqLine <= '0;
    else irqLine <= lineNext;
  end

  always_comb begin
    selRead = '0;
    for (int k = 0; k < NUM_DED; k++) selRead[k*STRIDE +: FLAG_W] = field[k];
  end

  assign rdData = strb.rdVec ? DATA_W'(vecReg) : selRead;

  always_comb begin
    if (qryFlag == FLAG_NONE) begin
      qryLine = CODE_NOCAP;
    end else begin
      if ((qryFlag < SRC_LIMIT) && vecReg[qryFlag[IDX_W-1:0]]) qryLine = CODE_SHARED;
      else qryLine = CODE_OFF;
      for (int k = NUM_DED - 1; k >= 0; k--) begin
        if (field[k] == qryFlag) qryLine = CODE_W'(k + 1);
      end
    end
  end

  assign qryIrq = (qryLine <= CODE_W'(NUM_DED)) ? 4'(qryLine) + 4'd2 : 4'd0;
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        regAddr,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  input  logic [31:0] srcReq,
  output logic [4:0]  irqLine,
  input  logic [5:0]  qryFlag,
  output logic [2:0]  qryLine,
  output logic [3:0]  qryIrq
);
  regStrobe_t strb;

  irq_router_ctrl u_ctrl (
    .wrEn(wrEn), .regAddr(regAddr), .strb(strb)
  );

  irq_router_dp #(.NUM_SRC(32), .NUM_DED(4), .DATA_W(32)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .rdData(rdData),
    .srcReq(srcReq), .irqLine(irqLine), .qryFlag(qryFlag),
    .qryLine(qryLine), .qryIrq(qryIrq)
  );
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic        regAddr,
  input logic [31:0] wrData,
  input logic [31:0] rdData,
  input logic [4:0]  irqLine,
  input logic [5:0]  qryFlag,
  input logic [2:0]  qryLine
);
  // R2
  sel_gap_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !regAddr |-> (rdData & 32'hC0C0_C0C0) == 32'h0);

  // R5
  nocap_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    qryFlag == 6'h3F |-> qryLine == 3'd6);

  // R5
  code_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    qryLine <= 3'd6);

  // R7
  vec_clear_query_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regAddr && wrData == 32'h0) |=> qryLine != 3'd0);

  // R7
  vec_clear_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regAddr && wrData == 32'h0) |=> ##1 !irqLine[0]);

  // R3
  release_all_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !regAddr && wrData == 32'hFFFF_FFFF) |=> ##1 irqLine[4:1] == 4'h0);
endmodule

bind irq_router irq_router_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
  .rdData(rdData), .irqLine(irqLine), .qryFlag(qryFlag), .qryLine(qryLine)
);

// File: tb/tb_irq_router.sv
`timescale 1ns/1ps
module tb_irq_router;
  logic        clk = 0;
  logic        rstN = 0;
  logic        wrEn = 0;
  logic        regAddr = 0;
  logic [31:0] wrData = 0;
  logic [31:0] rdData;
  logic [31:0] srcReq = 0;
  logic [4:0]  irqLine;
  logic [5:0]  qryFlag = 0;
  logic [2:0]  qryLine;
  logic [3:0]  qryIrq;
  int nChk = 0, nBad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_router dut (.*);

  localparam int NV = 6;
  localparam logic [31:0] T_SEL [NV] = '{32'h03020100, 32'h03020100, 32'h3F3F3F05,
                                          32'h05050505, 32'h3F203F3F, 32'hC0C0C0C1};
  localparam logic [31:0] T_VEC [NV] = '{32'h10, 32'h10, 32'h80000001, 32'h20, 32'h0, 32'h2};
  localparam logic [31:0] T_SRC [NV] = '{32'h1F, 32'h0A, 32'h80000020, 32'h20, 32'hFFFFFFFF, 32'h3};
  localparam logic [4:0]  T_LIN [NV] = '{5'b11111, 5'b10100, 5'b00011, 5'b11111, 5'b00000, 5'b11111};
  localparam logic [5:0]  T_QF  [NV] = '{6'd2, 6'd4, 6'd9, 6'd5, 6'h20, 6'd0};
  localparam logic [2:0]  T_QL  [NV] = '{3'd3, 3'd0, 3'd5, 3'd1, 3'd3, 3'd2};

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [31:0] d);
    @(negedge clk);
    wrEn = 1; regAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic query(string req, logic [5:0] f, logic [2:0] expL);
    qryFlag = f;
    #1;
    chk(req, 32'(qryLine), 32'(expL));
    chk("R6", 32'(qryIrq), (expL <= 3'd4) ? 32'(expL) + 32'd2 : 32'd0);
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  endtask

  initial begin
    #200000;
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog: actual hung expected done");
      finishRun();
    end
  end

  initial begin
    #20;
    @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", 32'(irqLine), 32'h0);
    regAddr = 0; #1; chk("R1", rdData, 32'h3F3F3F3F);
    regAddr = 1; #1; chk("R1", rdData, 32'h0);
    query("R1", 6'd0, 3'd5);

    // R2 R3 R4 R5 table walk
    for (int i = 0; i < NV; i++) begin
      wr(1'b0, T_SEL[i]);
      wr(1'b1, T_VEC[i]);
      srcReq = T_SRC[i];
      @(negedge clk);
      chk("R3/R4 lines", 32'(irqLine), 32'(T_LIN[i]));
      regAddr = 0; #1;
      chk("R2", rdData, T_SEL[i] & 32'h3F3F3F3F);
      regAddr = 1; #1;
      chk("R4 readback", rdData, T_VEC[i]);
      query("R5", T_QF[i], T_QL[i]);
    end

    // R5 no-capability flag beats every match
    wr(1'b0, 32'hFFFFFFFF);
    wr(1'b1, 32'hFFFFFFFF);
    query("R5 nocap", 6'h3F, 3'd6);
    query("R5 shared", 6'd31, 3'd0);
    query("R5 above range", 6'd40, 3'd5);

    // R7 vector clear
    srcReq = 32'h1;
    @(negedge clk);
    chk("R7 before", 32'(irqLine), 32'h1);
    wr(1'b1, 32'h0);
    query("R7", 6'd0, 3'd5);
    @(negedge clk);
    chk("R7 line0", 32'(irqLine), 32'h0);

    // R3 latency on a dedicated line
    wr(1'b0, 32'h3F3F3F07);
    srcReq = 32'h0;
    @(negedge clk);
    chk("R3 idle", 32'(irqLine), 32'h0);
    srcReq = 32'h80;
    #1;
    chk("R3 before edge", 32'(irqLine), 32'h0);
    @(negedge clk);
    chk("R3 after edge", 32'(irqLine), 32'h2);

    // R8 write timing and read mux
    @(negedge clk);
    wrEn = 1; regAddr = 0; wrData = 32'h01010101;
    #1;
    chk("R8 old value", rdData, 32'h3F3F3F07);
    @(negedge clk);
    wrEn = 0;
    #1;
    chk("R8 new value", rdData, 32'h01010101);

    done = 1;
    finishRun();
  end
endmodule